// File: doc/BRIEF.md
# Serial Control Port with Discarded First Write

This block is the configuration interface of an audio converter. It sits beside the audio data path but does not follow its frame timing. An external controller drives a control clock, an active-low select and a data-in line. Each transaction is a 32-bit word shifted in most significant bit first. The word carries two attenuation fields and two gain fields. The block stores them without interpreting them further. While the word comes in, 32 status bits go out on the data-out line in the same cycle positions.

All serial inputs are resynchronised into the master clock domain, so the port does nothing when the master clock is stopped. After a reset, and again after every power-down, the first complete transaction only arms the port: its data is thrown away. An init-done flag rises when that transaction ends. Only transactions after that reach the configuration registers. Those registers keep their value until the next accepted write, so the controller needs to talk to the port only when a setting changes or status is wanted.

Top module: `ctl_port`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `init_done_o` is 0, all four configuration outputs are 0 and `sdo_o` is 0.
- R2: After reset, the first complete frame leaves the configuration outputs unchanged. `init_done_o` rises when that frame ends.
- R3: Every complete frame after that loads its word W as follows: `l_att_o`=W[31:24], `r_att_o`=W[23:16], `l_gain_o`=W[15:8], `r_gain_o`=W[7:0].
- R4: The configuration outputs change only when an accepted frame ends. Control-clock edges while `csn_i` is high have no effect.
- R5: A frame is complete only if exactly 32 rising control-clock edges occur while `csn_i` is low. A shorter or longer frame is discarded and does not count as the discarded first write.
- R6: When `csn_i` falls, `status_i` is captured. `sdo_o` presents bit 31 of the captured value first and moves to the next lower bit after each rising control-clock edge. This happens in every frame, including the discarded first one. `sdo_o` is 0 while `csn_i` is high.
- R7: While `pdn_i` is high, `init_done_o` is 0 from the next cycle on and completed frames are discarded. The configuration outputs keep their values. After `pdn_i` falls, the first complete frame is discarded again and later frames load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all state advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pdn_i | input | 1 | Power-down request, master clock domain |
| sck_i | input | 1 | Control clock, asynchronous |
| csn_i | input | 1 | Frame select, active low, asynchronous |
| sdi_i | input | 1 | Serial write data, sampled on rising control-clock edge |
| sdo_o | output | 1 | Serial status data |
| status_i | input | 32 | Status word returned during each frame |
| init_done_o | output | 1 | High once the discarded first write has completed |
| l_att_o | output | 8 | Left attenuation setting |
| r_att_o | output | 8 | Right attenuation setting |
| l_gain_o | output | 8 | Left gain setting |
| r_gain_o | output | 8 | Right gain setting |

## Verification
The assertions check the following on every cycle:
- the configuration registers never move except in the cycle after a load;
- a load never happens before init-done;
- init-done rises only after a complete frame and drops after power-down;
- `sdo_o` holds steady between control-clock edges inside a frame.

Only the bench scenarios can show the rest:
- the field layout of stored words;
- the exact bit order of the status stream;
- that each aborted length from 0 to 31 bits, and an overlong frame, leave the port still waiting for its discarded write;
- the re-arming sequence after power-down.

// File: rtl/ctlp_pkg.sv
package ctlp_pkg;

    localparam int FIELD_W    = 8;
    localparam int NFIELDS    = 4;
    localparam int FRAME_BITS = FIELD_W * NFIELDS;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);

    typedef struct packed {
        logic [FIELD_W-1:0] l_att;
        logic [FIELD_W-1:0] r_att;
        logic [FIELD_W-1:0] l_gain;
        logic [FIELD_W-1:0] r_gain;
    } ctl_cfg_t;

    typedef enum logic {
        INIT_AWAIT = 1'b0,
        INIT_READY = 1'b1
    } init_st_t;

    typedef struct packed {
        logic                  done;
        logic                  ok;
        logic [FRAME_BITS-1:0] data;
    } frame_t;

    function automatic ctl_cfg_t word_to_cfg(input logic [FRAME_BITS-1:0] w);
        ctl_cfg_t c;
        c.l_att  = w[4*FIELD_W-1:3*FIELD_W];
        c.r_att  = w[3*FIELD_W-1:2*FIELD_W];
        c.l_gain = w[2*FIELD_W-1:FIELD_W];
        c.r_gain = w[FIELD_W-1:0];
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] c);
        logic [CNT_W-1:0] lim;
        lim = CNT_W'(FRAME_BITS + 1);
        return (c < lim) ? c + 1'b1 : c;
    endfunction

endpackage

// File: rtl/ctlp_sync.sv
module ctlp_sync #(
    parameter int              NSIG    = 3,
    parameter int              STAGES  = 2,
    parameter logic [NSIG-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSIG-1:0] async_i,
    output logic [NSIG-1:0] sync_o,
    output logic [NSIG-1:0] prev_o
);

    localparam int CHAIN = STAGES + 1;

    for (genvar s = 0; s < NSIG; s++) begin : g_sig
        logic [CHAIN-1:0] chain_q;
        always_ff @(posedge clk) begin
            if (rst) chain_q <= {CHAIN{RST_VAL[s]}};
            else     chain_q <= {chain_q[CHAIN-2:0], async_i[s]};
        end
        assign sync_o[s] = chain_q[STAGES-1];
        assign prev_o[s] = chain_q[STAGES];
    end

endmodule

// File: rtl/ctlp_shifter.sv
module ctlp_shifter
    import ctlp_pkg::*;
#(
    parameter int NBITS = FRAME_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sck_s,
    input  logic             sck_d,
    input  logic             csn_s,
    input  logic             csn_d,
    input  logic             sdi_s,
    input  logic [NBITS-1:0] status_i,
    output logic             sdo_o,
    output frame_t           frame_o
);

    logic             sel_fall, sel_rise, sck_rise;
    logic [CNT_W-1:0] cnt_q;
    logic [NBITS-1:0] in_sr_q, out_sr_q;
    frame_t           frame_q;

    assign sel_fall = csn_d & ~csn_s;
    assign sel_rise = ~csn_d & csn_s;
    assign sck_rise = ~sck_d & sck_s & ~csn_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            in_sr_q  <= '0;
            out_sr_q <= '0;
        end else if (sel_fall) begin
            cnt_q    <= '0;
            out_sr_q <= status_i;
        end else if (sck_rise) begin
            cnt_q    <= cnt_step(cnt_q);
            in_sr_q  <= {in_sr_q[NBITS-2:0], sdi_s};
            out_sr_q <= {out_sr_q[NBITS-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else begin
            frame_q.done <= sel_rise;
            frame_q.ok   <= sel_rise && (cnt_q == CNT_W'(NBITS));
            frame_q.data <= in_sr_q;
        end
    end

    assign sdo_o   = ~csn_s & out_sr_q[NBITS-1];
    assign frame_o = frame_q;

    // R6
    sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!csn_s && $past(!csn_s && !csn_d && !sck_rise)) |-> $stable(sdo_o));

    // R5
    ok_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        frame_q.ok |-> frame_q.done);

endmodule

// File: rtl/ctlp_init_fsm.sv
module ctlp_init_fsm
    import ctlp_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pdn_i,
    input  frame_t frame_i,
    output logic   load_o,
    output logic   init_done_o
);

    init_st_t st_q, st_d;
    logic     accept;

    assign accept = frame_i.done & frame_i.ok & ~pdn_i;

    always_comb begin
        st_d = st_q;
        if (pdn_i) begin
            st_d = INIT_AWAIT;
        end else if (accept && st_q == INIT_AWAIT) begin
            st_d = INIT_READY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= INIT_AWAIT;
        else     st_q <= st_d;
    end

    assign load_o      = accept && (st_q == INIT_READY);
    assign init_done_o = (st_q == INIT_READY);

    // R2
    rise_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done_o) |-> $past(frame_i.done && frame_i.ok));

    // R7
    pdn_clears_chk: assert property (@(posedge clk) disable iff (rst)
        pdn_i |=> !init_done_o);

endmodule

// File: rtl/ctlp_cfg_regs.sv
module ctlp_cfg_regs
    import ctlp_pkg::*;
#(
    parameter int NBITS = FRAME_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [NBITS-1:0] word_i,
    output ctl_cfg_t         cfg_o
);

    ctl_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (load_i) cfg_q <= word_to_cfg(word_i);
    end

    assign cfg_o = cfg_q;

    // R4
    cfg_only_on_load_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_q) |-> $past(load_i));

    // R1
    cfg_reset_chk: assert property (@(posedge clk)
        rst |=> (cfg_q == '0));

endmodule

// File: rtl/ctl_port.sv
module ctl_port
    import ctlp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pdn_i,
    input  logic                  sck_i,
    input  logic                  csn_i,
    input  logic                  sdi_i,
    output logic                  sdo_o,
    input  logic [FRAME_BITS-1:0] status_i,
    output logic                  init_done_o,
    output logic [FIELD_W-1:0]    l_att_o,
    output logic [FIELD_W-1:0]    r_att_o,
    output logic [FIELD_W-1:0]    l_gain_o,
    output logic [FIELD_W-1:0]    r_gain_o
);

    localparam int           NSIG    = 3;
    localparam logic [2:0]   SYNC_RV = 3'b010;

    logic [NSIG-1:0] sync_w, prev_w;
    frame_t          frame_w;
    logic            load_w;
    ctl_cfg_t        cfg_w;

    ctlp_sync #(
        .NSIG    (NSIG),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RV)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({sck_i, csn_i, sdi_i}),
        .sync_o  (sync_w),
        .prev_o  (prev_w)
    );

    ctlp_shifter #(
        .NBITS (FRAME_BITS)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .sck_s    (sync_w[2]),
        .sck_d    (prev_w[2]),
        .csn_s    (sync_w[1]),
        .csn_d    (prev_w[1]),
        .sdi_s    (sync_w[0]),
        .status_i (status_i),
        .sdo_o    (sdo_o),
        .frame_o  (frame_w)
    );

    ctlp_init_fsm u_init (
        .clk         (clk),
        .rst         (rst),
        .pdn_i       (pdn_i),
        .frame_i     (frame_w),
        .load_o      (load_w),
        .init_done_o (init_done_o)
    );

    ctlp_cfg_regs #(
        .NBITS (FRAME_BITS)
    ) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load_i (load_w),
        .word_i (frame_w.data),
        .cfg_o  (cfg_w)
    );

    assign l_att_o  = cfg_w.l_att;
    assign r_att_o  = cfg_w.r_att;
    assign l_gain_o = cfg_w.l_gain;
    assign r_gain_o = cfg_w.r_gain;

    // R3
    load_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
        load_w |-> init_done_o);

    // R1
    idle_sdo_chk: assert property (@(posedge clk)
        rst |=> (!init_done_o && !sdo_o));

endmodule

// File: tb/ctl_port_bench.sv
module ctl_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 4;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pdn = 1'b0;
    logic        sck = 1'b0;
    logic        csn = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [31:0] status = '0;
    logic        init_done;
    logic [7:0]  l_att, r_att, l_gain, r_gain;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_port u_ctl_port (
        .clk         (clk),
        .rst         (rst),
        .pdn_i       (pdn),
        .sck_i       (sck),
        .csn_i       (csn),
        .sdi_i       (sdi),
        .sdo_o       (sdo),
        .status_i    (status),
        .init_done_o (init_done),
        .l_att_o     (l_att),
        .r_att_o     (r_att),
        .l_gain_o    (l_gain),
        .r_gain_o    (r_gain)
    );

    function automatic logic [31:0] cfg_word();
        return {l_att, r_att, l_gain, r_gain};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send nbits of w (MSB first); check status stream on sdo (R6)
    task automatic run_frame(input logic [31:0] w, input int nbits,
                             input logic [31:0] st);
        logic [31:0] got = '0;
        logic [31:0] msk = '0;
        status = st;
        ticks(2);
        csn = 1'b0;
        ticks(8);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 32) ? w[31-i] : 1'b0;
            ticks(HALF_SCK);
            if (i < 32) begin
                got[31-i] = sdo;
                msk[31-i] = 1'b1;
            end
            sck = 1'b1;
            ticks(HALF_SCK);
            sck = 1'b0;
        end
        ticks(HALF_SCK);
        csn = 1'b1;
        sdi = 1'b0;
        ticks(12);
        if (nbits > 0)
            chk((got & msk) == (st & msk), "R6 status stream", got & msk, st & msk);
    endtask

    initial begin
        ticks(WATCHDOG);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=0", WATCHDOG);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] exp_cfg;
        ticks(5);
        // R1 reset state
        chk(!init_done, "R1 init_done", 32'(init_done), 0);
        chk(cfg_word() == 0, "R1 cfg", cfg_word(), 0);
        chk(!sdo, "R1 sdo", 32'(sdo), 0);
        rst = 1'b0;
        ticks(3);
        chk(!sdo, "R6 sdo idle", 32'(sdo), 0);

        // R5 sweep of every short length, then an overlong frame
        for (int n = 0; n < 32; n++) begin
            run_frame(32'hA5A5_0000 | 32'(n), n, 32'hC0DE_0000 + 32'(n));
            chk(!init_done, "R5 short frame init", 32'(init_done), 0);
            chk(cfg_word() == 0, "R5 short frame cfg", cfg_word(), 0);
        end
        run_frame(32'h1234_5678, 33, 32'h8000_0001);
        chk(!init_done, "R5 long frame init", 32'(init_done), 0);

        // R2 discarded first write
        run_frame(32'hDEAD_BEEF, 32, 32'h5A5A_A5A5);
        chk(init_done, "R2 init_done", 32'(init_done), 1);
        chk(cfg_word() == 0, "R2 cfg untouched", cfg_word(), 0);

        // R3 walking ones and field patterns
        for (int b = 0; b < 32; b++) begin
            exp_cfg = 32'h1 << b;
            run_frame(exp_cfg, 32, ~exp_cfg);
            chk(cfg_word() == exp_cfg, "R3 walk", cfg_word(), exp_cfg);
            chk(l_att == exp_cfg[31:24] && r_gain == exp_cfg[7:0],
                "R3 fields", {l_att, r_gain, 16'h0}, {exp_cfg[31:24], exp_cfg[7:0], 16'h0});
        end
        exp_cfg = 32'h1122_3344;
        run_frame(exp_cfg, 32, 32'hFFFF_0000);
        chk(l_att == 8'h11 && r_att == 8'h22 && l_gain == 8'h33 && r_gain == 8'h44,
            "R3 layout", cfg_word(), exp_cfg);

        // R4 clock activity with select high changes nothing
        for (int k = 0; k < 40; k++) begin
            sdi = k[0];
            ticks(HALF_SCK); sck = 1'b1;
            ticks(HALF_SCK); sck = 1'b0;
        end
        ticks(12);
        chk(cfg_word() == exp_cfg, "R4 hold", cfg_word(), exp_cfg);
        run_frame(32'h0BAD_0BAD, 17, 32'h0);
        chk(cfg_word() == exp_cfg, "R4 R5 abort after ready", cfg_word(), exp_cfg);

        // R7 power-down
        pdn = 1'b1;
        ticks(2);
        chk(!init_done, "R7 init cleared", 32'(init_done), 0);
        chk(cfg_word() == exp_cfg, "R7 cfg kept", cfg_word(), exp_cfg);
        run_frame(32'hAAAA_5555, 32, 32'h3C3C_C3C3);
        chk(!init_done && cfg_word() == exp_cfg, "R7 frame during pdn",
            cfg_word(), exp_cfg);
        pdn = 1'b0;
        ticks(4);
        run_frame(32'h7777_8888, 32, 32'h0F0F_F0F0);
        chk(init_done, "R7 re-armed", 32'(init_done), 1);
        chk(cfg_word() == exp_cfg, "R7 first write discarded", cfg_word(), exp_cfg);
        run_frame(32'hCAFE_F00D, 32, 32'h1357_9BDF);
        chk(cfg_word() == 32'hCAFE_F00D, "R7 second write loads",
            cfg_word(), 32'hCAFE_F00D);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule